// File: doc/BRIEF.md
# Weighted Threshold Gate with Hysteresis

This block models one threshold element of the kind used in quasi-delay-insensitive dual-rail logic. It runs on a sampling clock. Each of the `N_IN` inputs carries a positive integer weight. At every rising clock edge the block compares weighted sums against a threshold `THRESH` and decides whether the stored bit is set, cleared or held. Because it holds its value between the two conditions, the element behaves like a C-element generalised to weighted thresholds.

A polarity parameter selects between two families. In the return-to-zero family, the set condition is the weighted threshold and the clear condition is "all inputs low". In the return-to-one family these roles are mirrored. An inversion parameter gives the negative-unate flavour, which drives out the complement of the stored bit. A further parameter enables two forcing pins that overwrite the stored bit directly. A synchronous initialisation input loads the spacer value of the chosen family. Out-of-range parameters stop elaboration: a threshold below 1, a threshold above the total weight, or any zero weight.

Top module: `wtg_gate`

## Requirements
- R1: When `init` is high at a rising edge, the stored bit becomes the spacer value (0 for return-to-zero, 1 for return-to-one) and is seen on `q` after that edge. `init` overrides the forcing pins and the threshold rules.
- R2: Return-to-zero (`POL` = `POL_RTZ`): the stored bit becomes 1 at an edge where the summed weight of inputs at 1 is at least `THRESH`.
- R3: Return-to-zero: the stored bit becomes 0 only at an edge where every input is 0.
- R4: Return-to-one (`POL` = `POL_RTO`): the stored bit becomes 1 only at an edge where every input is 1.
- R5: Return-to-one: the stored bit becomes 0 at an edge where the summed weight of inputs at 0 is at least `THRESH`.
- R6: An input pattern that meets neither the set nor the clear condition of the selected family leaves the stored bit, and therefore `q`, unchanged.
- R7: With `INVERT` = 1, `q` is the complement of the stored bit. With `INVERT` = 0, `q` equals the stored bit.
- R8: With `HAS_SETRST` = 1 and `init` low, `force_clr` high makes the stored bit 0 at the edge, even when `force_set` is also high. `force_set` high alone makes it 1. Both pins take precedence over the threshold rules.
- R9: With `HAS_SETRST` = 0, `force_set` and `force_clr` have no effect on `q`.
- R10: `WEIGHTS` packs one `WGT_W`-bit field per input, with input i's weight in bits [i*WGT_W +: WGT_W]. The default gives every input weight 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock; all updates on its rising edge |
| init | input | 1 | Synchronous load of the spacer value |
| din | input | N_IN | Threshold inputs |
| force_set | input | 1 | Forces the stored bit to 1 (when enabled) |
| force_clr | input | 1 | Forces the stored bit to 0, wins over force_set (when enabled) |
| q | output | 1 | Stored bit, complemented when INVERT is set |

## Verification
The bench builds three instances side by side.

- The first uses the defaults: three inputs of unit weight, threshold 2, return-to-zero, no forcing pins. This reproduces the classic two-of-three hysteresis gate and shows that the pins are ignored.
- The second has three inputs weighted 1, 2 and 3, threshold 3, return-to-one polarity, inverted output and forcing pins. This reaches the mirrored rules, the complemented output and the pin priority.
- The third has four inputs weighted 1, 1, 2 and 3 with threshold 4 in return-to-zero. Here unequal weights separate patterns of the same population count.

All ordered pairs of input patterns are swept through every instance, so each pattern is applied from both stored states.

// File: rtl/wtg_pkg.sv
package wtg_pkg;

   typedef enum logic {
      POL_RTZ = 1'b0,
      POL_RTO = 1'b1
   } wtg_pol_e;

   typedef enum logic [1:0] {
      ACT_HOLD = 2'd0,
      ACT_SET  = 2'd1,
      ACT_CLR  = 2'd2
   } wtg_act_e;

   function automatic logic spacer_of(wtg_pol_e pol);
      return (pol == POL_RTO) ? 1'b1 : 1'b0;
   endfunction

endpackage

// File: rtl/wtg_wsum.sv
module wtg_wsum #(
   parameter int unsigned            N_IN    = 3,
   parameter int unsigned            WGT_W   = 4,
   parameter int unsigned            SUM_W   = 6,
   parameter logic [N_IN*WGT_W-1:0]  WEIGHTS = '0
) (
   input  logic [N_IN-1:0]  pick,
   output logic [SUM_W-1:0] total
);

   logic [SUM_W-1:0] term [N_IN];

   for (genvar i = 0; i < N_IN; i++) begin : g_term
      localparam logic [SUM_W-1:0] WI = SUM_W'(WEIGHTS[i*WGT_W +: WGT_W]);
      assign term[i] = pick[i] ? WI : '0;
   end

   always_comb begin
      total = '0;
      for (int i = 0; i < N_IN; i++) begin
         total = total + term[i];
      end
   end

endmodule

// File: rtl/wtg_decide.sv
module wtg_decide
   import wtg_pkg::*;
#(
   parameter int unsigned N_IN   = 3,
   parameter int unsigned SUM_W  = 6,
   parameter int unsigned THRESH = 2,
   parameter wtg_pol_e    POL    = POL_RTZ
) (
   input  logic [N_IN-1:0]  din,
   input  logic [SUM_W-1:0] high_sum,
   input  logic [SUM_W-1:0] low_sum,
   output wtg_act_e         act
);

   localparam logic [SUM_W-1:0] TH = SUM_W'(THRESH);

   if (POL == POL_RTZ) begin : g_rtz
      logic unused_low;
      assign unused_low = ^low_sum;
      always_comb begin
         if (high_sum >= TH)      act = ACT_SET;
         else if (din == '0)      act = ACT_CLR;
         else                     act = ACT_HOLD;
      end
   end else begin : g_rto
      logic unused_high;
      assign unused_high = ^high_sum;
      always_comb begin
         if (&din)                act = ACT_SET;
         else if (low_sum >= TH)  act = ACT_CLR;
         else                     act = ACT_HOLD;
      end
   end

endmodule

// File: rtl/wtg_state.sv
module wtg_state
   import wtg_pkg::*;
#(
   parameter wtg_pol_e POL        = POL_RTZ,
   parameter bit       INVERT     = 1'b0,
   parameter bit       HAS_SETRST = 1'b0
) (
   input  logic     clk,
   input  logic     init,
   input  wtg_act_e act,
   input  logic     force_set,
   input  logic     force_clr,
   output logic     q
);

   localparam logic SPACER = spacer_of(POL);

   logic set_eff;
   logic clr_eff;
   logic st;

   if (HAS_SETRST) begin : g_pins
      assign set_eff = force_set;
      assign clr_eff = force_clr;
   end else begin : g_nopins
      logic unused_pins;
      assign unused_pins = force_set ^ force_clr;
      assign set_eff = 1'b0;
      assign clr_eff = 1'b0;
   end

   always_ff @(posedge clk) begin
      if (init)          st <= SPACER;
      else if (clr_eff)  st <= 1'b0;
      else if (set_eff)  st <= 1'b1;
      else begin
         case (act)
            ACT_SET: st <= 1'b1;
            ACT_CLR: st <= 1'b0;
            default: st <= st;
         endcase
      end
   end

   if (INVERT) begin : g_neg
      assign q = ~st;
   end else begin : g_pos
      assign q = st;
   end

endmodule

// File: rtl/wtg_gate.sv
module wtg_gate
   import wtg_pkg::*;
#(
   parameter int unsigned           N_IN       = 3,
   parameter int unsigned           WGT_W      = 4,
   parameter int unsigned           THRESH     = 2,
   parameter logic [N_IN*WGT_W-1:0] WEIGHTS    = {N_IN{WGT_W'(1)}},
   parameter wtg_pol_e              POL        = POL_RTZ,
   parameter bit                    INVERT     = 1'b0,
   parameter bit                    HAS_SETRST = 1'b0
) (
   input  logic            clk,
   input  logic            init,
   input  logic [N_IN-1:0] din,
   input  logic            force_set,
   input  logic            force_clr,
   output logic            q
);

   function automatic int unsigned weight_total();
      int unsigned acc = 0;
      for (int i = 0; i < N_IN; i++) acc += 32'(WEIGHTS[i*WGT_W +: WGT_W]);
      return acc;
   endfunction

   function automatic int unsigned zero_weights();
      int unsigned cnt = 0;
      for (int i = 0; i < N_IN; i++) if (WEIGHTS[i*WGT_W +: WGT_W] == '0) cnt++;
      return cnt;
   endfunction

   localparam int unsigned MAX_SUM = N_IN * ((1 << WGT_W) - 1);
   localparam int unsigned SUM_W   = $clog2(MAX_SUM + 1);
   localparam int unsigned W_TOTAL = weight_total();
   localparam int unsigned W_ZEROS = zero_weights();

   if (N_IN < 1) begin : g_bad_n
      $error("wtg_gate: N_IN must be at least 1");
   end
   if (THRESH < 1 || THRESH > W_TOTAL) begin : g_bad_thresh
      $error("wtg_gate: THRESH must lie in 1..total weight");
   end
   if (W_ZEROS != 0) begin : g_bad_weight
      $error("wtg_gate: every weight must be nonzero");
   end

   logic [SUM_W-1:0] high_sum;
   logic [SUM_W-1:0] low_sum;
   wtg_act_e         act;

   wtg_wsum #(
      .N_IN   (N_IN),
      .WGT_W  (WGT_W),
      .SUM_W  (SUM_W),
      .WEIGHTS(WEIGHTS)
   ) u_high_sum (
      .pick  (din),
      .total (high_sum)
   );

   wtg_wsum #(
      .N_IN   (N_IN),
      .WGT_W  (WGT_W),
      .SUM_W  (SUM_W),
      .WEIGHTS(WEIGHTS)
   ) u_low_sum (
      .pick  (~din),
      .total (low_sum)
   );

   wtg_decide #(
      .N_IN  (N_IN),
      .SUM_W (SUM_W),
      .THRESH(THRESH),
      .POL   (POL)
   ) u_decide (
      .din      (din),
      .high_sum (high_sum),
      .low_sum  (low_sum),
      .act      (act)
   );

   wtg_state #(
      .POL       (POL),
      .INVERT    (INVERT),
      .HAS_SETRST(HAS_SETRST)
   ) u_state (
      .clk       (clk),
      .init      (init),
      .act       (act),
      .force_set (force_set),
      .force_clr (force_clr),
      .q         (q)
   );

endmodule

// File: rtl/wtg_checker.sv
module wtg_checker
   import wtg_pkg::*;
#(
   parameter int unsigned N_IN       = 3,
   parameter wtg_pol_e    POL        = POL_RTZ,
   parameter bit          INVERT     = 1'b0,
   parameter bit          HAS_SETRST = 1'b0
) (
   input logic            clk,
   input logic            init,
   input logic [N_IN-1:0] din,
   input logic            force_set,
   input logic            force_clr,
   input wtg_act_e        act,
   input logic            q
);

   localparam logic SPACER = spacer_of(POL);
   localparam logic INV_L  = INVERT;
   localparam logic PINS_L = HAS_SETRST;

   logic started = 1'b0;
   always_ff @(posedge clk) if (init) started <= 1'b1;

   logic live;
   logic pins_live;
   logic stored;
   assign live      = started | init;
   assign pins_live = PINS_L & (force_set | force_clr);
   assign stored    = q ^ INV_L;

   a_r1_init_spacer: assert property (@(posedge clk) disable iff (!live)
      init |=> stored == SPACER);

   a_r2_r4_all_high_sets: assert property (@(posedge clk) disable iff (!live)
      (!init && !pins_live && (&din)) |=> stored == 1'b1);

   a_r3_r5_all_low_clears: assert property (@(posedge clk) disable iff (!live)
      (!init && !pins_live && din == '0) |=> stored == 1'b0);

   a_r6_hold_stable: assert property (@(posedge clk) disable iff (!live)
      (!init && !pins_live && act == ACT_HOLD) |=> $stable(q));

   a_r8_clr_priority: assert property (@(posedge clk) disable iff (!live)
      (PINS_L && !init && force_clr) |=> stored == 1'b0);

   a_r8_set_forces: assert property (@(posedge clk) disable iff (!live)
      (PINS_L && !init && force_set && !force_clr) |=> stored == 1'b1);

endmodule

bind wtg_gate wtg_checker #(
   .N_IN      (N_IN),
   .POL       (POL),
   .INVERT    (INVERT),
   .HAS_SETRST(HAS_SETRST)
) u_wtg_checker (
   .clk       (clk),
   .init      (init),
   .din       (din),
   .force_set (force_set),
   .force_clr (force_clr),
   .act       (act),
   .q         (q)
);

// File: tb/wtg_gate_bench.sv
`timescale 1ns/1ps
module wtg_gate_bench;
   import wtg_pkg::*;

   localparam logic [11:0] W_B = {4'd3, 4'd2, 4'd1};
   localparam logic [15:0] W_C = {4'd3, 4'd2, 4'd1, 4'd1};
   localparam logic [15:0] W_A16 = {4'd0, 4'd1, 4'd1, 4'd1};
   localparam logic [15:0] W_B16 = {4'd0, W_B};

   logic       clk = 1'b0;
   logic       init;
   logic [3:0] d;
   logic       fs, fc;
   logic       q_a, q_b, q_c;
   logic       m_a, m_b, m_c;
   int         n_chk = 0;
   int         n_bad = 0;
   bit         done = 1'b0;

   always #2 clk = ~clk;

   // A: defaults (3 inputs, weight 1, M=2, return-to-zero, no pins)
   wtg_gate u_wtg_gate (
      .clk(clk), .init(init), .din(d[2:0]),
      .force_set(fs), .force_clr(fc), .q(q_a));

   // B: weights 1,2,3, M=3, return-to-one, inverted, pins
   wtg_gate #(.N_IN(3), .THRESH(3), .WEIGHTS(W_B), .POL(POL_RTO),
              .INVERT(1'b1), .HAS_SETRST(1'b1)) u_wtg_gate_b (
      .clk(clk), .init(init), .din(d[2:0]),
      .force_set(fs), .force_clr(fc), .q(q_b));

   // C: weights 1,1,2,3, M=4, return-to-zero, pins
   wtg_gate #(.N_IN(4), .THRESH(4), .WEIGHTS(W_C), .POL(POL_RTZ),
              .INVERT(1'b0), .HAS_SETRST(1'b1)) u_wtg_gate_c (
      .clk(clk), .init(init), .din(d),
      .force_set(fs), .force_clr(fc), .q(q_c));

   function automatic logic nxt(logic st, bit rto, int n, int m,
                                logic [15:0] w, logic [3:0] x);
      int on = 0;
      int off = 0;
      bit allhi = 1'b1;
      bit alllo = 1'b1;
      for (int i = 0; i < n; i++) begin
         if (x[i]) begin on += int'(w[i*4 +: 4]); alllo = 1'b0; end
         else      begin off += int'(w[i*4 +: 4]); allhi = 1'b0; end
      end
      if (!rto) begin
         if (on >= m) return 1'b1;
         if (alllo)   return 1'b0;
         return st;
      end
      if (allhi)    return 1'b1;
      if (off >= m) return 1'b0;
      return st;
   endfunction

   function automatic string tag(bit rto, int n, int m,
                                 logic [15:0] w, logic [3:0] x);
      int on = 0;
      int off = 0;
      bit allhi = 1'b1;
      bit alllo = 1'b1;
      for (int i = 0; i < n; i++) begin
         if (x[i]) begin on += int'(w[i*4 +: 4]); alllo = 1'b0; end
         else      begin off += int'(w[i*4 +: 4]); allhi = 1'b0; end
      end
      if (!rto) return (on >= m) ? "R2" : (alllo ? "R3" : "R6");
      return allhi ? "R4" : ((off >= m) ? "R5" : "R6");
   endfunction

   task automatic check(string req, logic act, logic exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: q=%b expected %b", req, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   // drive one cycle of data and pins, update models, check after the edge
   task automatic apply(logic [3:0] x, logic s, logic c);
      string ta, tb, tc;
      d = x; fs = s; fc = c; init = 1'b0;
      ta = (s | c) ? "R9" : tag(1'b0, 3, 2, W_A16, x);
      tb = c ? "R8 clr" : (s ? "R8 set" : tag(1'b1, 3, 3, W_B16, x));
      tc = c ? "R8 clr" : (s ? "R8 set" : tag(1'b0, 4, 4, W_C, x));
      m_a = nxt(m_a, 1'b0, 3, 2, W_A16, x);
      m_b = c ? 1'b0 : (s ? 1'b1 : nxt(m_b, 1'b1, 3, 3, W_B16, x));
      m_c = c ? 1'b0 : (s ? 1'b1 : nxt(m_c, 1'b0, 4, 4, W_C, x));
      step();
      check({"A R10 ", ta}, q_a, m_a);
      check({"B R7 ", tb}, q_b, ~m_b);
      check({"C R10 ", tc}, q_c, m_c);
   endtask

   task automatic do_init(logic [3:0] x, logic s, logic c);
      d = x; fs = s; fc = c; init = 1'b1;
      m_a = 1'b0; m_b = 1'b1; m_c = 1'b0;
      step();
      check("A R1 init spacer", q_a, 1'b0);
      check("B R1 R7 init spacer", q_b, 1'b0);
      check("C R1 init spacer", q_c, 1'b0);
      init = 1'b0;
   endtask

   initial begin
      init = 1'b1; d = '0; fs = 1'b0; fc = 1'b0;
      m_a = 1'b0; m_b = 1'b1; m_c = 1'b0;
      do_init(4'h0, 1'b0, 1'b0);

      // all ordered pattern pairs, each pattern seen from both stored states
      for (int p = 0; p < 16; p++) begin
         for (int r = 0; r < 16; r++) begin
            apply(4'(p), 1'b0, 1'b0);
            apply(4'(r), 1'b0, 1'b0);
         end
      end

      // pins: set against a clearing pattern, clear against a setting one
      apply(4'h0, 1'b1, 1'b0);
      apply(4'hF, 1'b1, 1'b1);
      apply(4'hF, 1'b0, 1'b1);
      apply(4'h1, 1'b1, 1'b0);
      apply(4'h2, 1'b0, 1'b1);
      apply(4'hF, 1'b0, 1'b0);
      apply(4'h1, 1'b0, 1'b1);
      apply(4'h1, 1'b1, 1'b0);

      // init wins over pins and data
      apply(4'hF, 1'b0, 1'b0);
      do_init(4'hF, 1'b1, 1'b0);
      do_init(4'h0, 1'b1, 1'b1);
      apply(4'h3, 1'b0, 1'b0);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: run did not complete, got hang expected finish");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

endmodule